// File: doc/BRIEF.md
# FIFO Threshold Interrupt Controller

This block gathers the interrupt conditions of an SPI master's transmit and receive FIFOs into one interrupt line. The shift engine supplies the live occupancy counts of both FIFOs and single-cycle strobes for fault events. The block compares each count against a threshold that software can program, and against the FIFO depth. It latches seven status bits and combines them with a software mask to drive one interrupt output.

Software reaches the block through a simple register port: a write strobe with a byte offset and write data, and read data decoded from the same offset without any read side effects. Status bits are cleared by writing ones to them. The mask is never written directly. One offset sets mask bits where ones are written, another offset clears them, and a third offset reads the mask back.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: Register offsets are 0x04 status, 0x08 mask-set, 0x0C mask-clear, 0x10 mask readback, 0x28 transmit threshold and 0x2C receive threshold. Reads of 0x08, 0x0C or any unmapped offset return 0.
- R2: After reset the mask is 0 and the thresholds are 1. Each status bit is 0, except the level conditions that hold during reset. With both counts at 0, status reads 0x04.
- R3: Status bit 2 sets when the transmit count is below the transmit threshold, so a threshold of 1 means the FIFO is empty.
- R4: Status bit 4 sets when the receive count is at or above the receive threshold, so a threshold of 1 means the FIFO is not empty.
- R5: Status bit 3 sets when the transmit count equals the transmit depth. Status bit 5 sets when the receive count equals the receive depth.
- R6: Status bit 0 latches the receive-overrun strobe, bit 1 the mode-fault strobe and bit 6 the transmit-underrun strobe. If a strobe arrives in the same cycle as a clear of its bit, the bit stays set.
- R7: A write to 0x04 clears exactly the status bits that are 1 in the written data. Every other status bit keeps its value.
- R8: If a level bit is cleared while its condition still holds, it reads 0 in the cycle after the write and sets again one cycle later.
- R9: A one written to 0x08 sets the matching mask bit, and a one written to 0x0C clears it. Zeros written to either offset leave the mask unchanged.
- R10: The interrupt output is high exactly when some status bit and its mask bit are both 1, in the same cycle.
- R11: Status bits are sticky. A set bit stays set after its condition goes away, until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset for reads and writes |
| wdata | input | DATA_W | Register write data |
| rdata | output | DATA_W | Read data for the register at addr |
| tx_level | input | CNT_W | Transmit FIFO occupancy |
| rx_level | input | CNT_W | Receive FIFO occupancy |
| rx_overrun_pulse | input | 1 | Receive overrun strobe, one cycle |
| mode_fault_pulse | input | 1 | Mode fault strobe, one cycle |
| tx_underrun_pulse | input | 1 | Transmit underrun strobe, one cycle |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches the following on every cycle:
- mask bits change only through the set and clear offsets, and always in the written direction;
- status bits never drop except under a status write;
- a strobe is always latched;
- a below-threshold transmit count always reaches bit 2 unless a clear of that bit coincides;
- an interrupt never asserts with an empty mask.

Only the directed scenarios can show the rest. That covers the reset pattern of the status bits, the exact threshold boundaries on both FIFOs after threshold writes, the one-cycle gap before a level bit sets again, and the priority of a strobe over a coincident clear. It also covers readback values at every offset.

// File: rtl/fic_pkg.sv
package fic_pkg;

   localparam int NUM_IRQ = 7;

   // Status bit positions (software decodes these)
   localparam int B_RX_OVR   = 0;
   localparam int B_MODE_FLT = 1;
   localparam int B_TX_LOW   = 2;
   localparam int B_TX_FULL  = 3;
   localparam int B_RX_AVAIL = 4;
   localparam int B_RX_FULL  = 5;
   localparam int B_TX_UNDR  = 6;

   // Bits that follow a level condition rather than a strobe
   localparam logic [NUM_IRQ-1:0] LEVEL_BITS = 7'b011_1100;

   // Register byte offsets
   localparam logic [7:0] OFF_STATUS = 8'h04;
   localparam logic [7:0] OFF_MSET   = 8'h08;
   localparam logic [7:0] OFF_MCLR   = 8'h0C;
   localparam logic [7:0] OFF_MASK   = 8'h10;
   localparam logic [7:0] OFF_TXTHR  = 8'h28;
   localparam logic [7:0] OFF_RXTHR  = 8'h2C;

   typedef struct packed {
      logic sts_clr;
      logic msk_set;
      logic msk_clr;
      logic txthr_wr;
      logic rxthr_wr;
   } wr_sel_t;

endpackage

// File: rtl/fic_reg_port.sv
module fic_reg_port
   import fic_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 7
) (
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [NUM_IRQ-1:0]  status,
   input  logic [NUM_IRQ-1:0]  mask,
   input  logic [CNT_W-1:0]    tx_thr,
   input  logic [CNT_W-1:0]    rx_thr,
   output wr_sel_t             wsel,
   output logic [DATA_W-1:0]   rdata
);

   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
   localparam logic [ADDR_W-1:0] A_MSET   = ADDR_W'(OFF_MSET);
   localparam logic [ADDR_W-1:0] A_MCLR   = ADDR_W'(OFF_MCLR);
   localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFF_MASK);
   localparam logic [ADDR_W-1:0] A_TXTHR  = ADDR_W'(OFF_TXTHR);
   localparam logic [ADDR_W-1:0] A_RXTHR  = ADDR_W'(OFF_RXTHR);

   always_comb begin
      wsel          = '0;
      wsel.sts_clr  = wr_en && (addr == A_STATUS);
      wsel.msk_set  = wr_en && (addr == A_MSET);
      wsel.msk_clr  = wr_en && (addr == A_MCLR);
      wsel.txthr_wr = wr_en && (addr == A_TXTHR);
      wsel.rxthr_wr = wr_en && (addr == A_RXTHR);
   end

   always_comb begin
      unique case (addr)
         A_STATUS: rdata = DATA_W'(status);
         A_MASK:   rdata = DATA_W'(mask);
         A_TXTHR:  rdata = DATA_W'(tx_thr);
         A_RXTHR:  rdata = DATA_W'(rx_thr);
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/fic_cond_eval.sv
module fic_cond_eval #(
   parameter int CNT_W    = 7,
   parameter int TX_DEPTH = 63,
   parameter int RX_DEPTH = 63
) (
   input  logic [CNT_W-1:0] tx_level,
   input  logic [CNT_W-1:0] rx_level,
   input  logic [CNT_W-1:0] tx_thr,
   input  logic [CNT_W-1:0] rx_thr,
   output logic             tx_low,
   output logic             tx_full,
   output logic             rx_avail,
   output logic             rx_full
);

   localparam logic [CNT_W-1:0] TX_TOP = CNT_W'(TX_DEPTH);
   localparam logic [CNT_W-1:0] RX_TOP = CNT_W'(RX_DEPTH);

   assign tx_low   = tx_level <  tx_thr;
   assign rx_avail = rx_level >= rx_thr;
   assign tx_full  = tx_level == TX_TOP;
   assign rx_full  = rx_level == RX_TOP;

endmodule

// File: rtl/fic_status_bank.sv
module fic_status_bank #(
   parameter int          NUM   = 7,
   parameter logic [NUM-1:0] LEVEL = '0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] cond,
   input  logic [NUM-1:0] clr,
   input  logic [NUM-1:0] rst_val,
   output logic [NUM-1:0] status
);

   for (genvar i = 0; i < NUM; i++) begin : g_bit
      if (LEVEL[i]) begin : g_level
         // A clear wins for one cycle; the condition re-sets the bit afterwards
         always_ff @(posedge clk) begin
            if (!rst_n) status[i] <= rst_val[i];
            else        status[i] <= ~clr[i] & (status[i] | cond[i]);
         end
      end else begin : g_event
         // A strobe is never lost, even against a coincident clear
         always_ff @(posedge clk) begin
            if (!rst_n) status[i] <= 1'b0;
            else        status[i] <= (status[i] & ~clr[i]) | cond[i];
         end
      end
   end

endmodule

// File: rtl/fic_mask_reg.sv
module fic_mask_reg #(
   parameter int NUM = 7
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           set_en,
   input  logic           clr_en,
   input  logic [NUM-1:0] bits,
   output logic [NUM-1:0] mask
);

   always_ff @(posedge clk) begin
      if (!rst_n)      mask <= '0;
      else if (set_en) mask <= mask | bits;
      else if (clr_en) mask <= mask & ~bits;
   end

endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
   import fic_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 7,
   parameter int TX_DEPTH   = 63,
   parameter int RX_DEPTH   = 63,
   parameter int TX_THR_RST = 1,
   parameter int RX_THR_RST = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [CNT_W-1:0]  tx_level,
   input  logic [CNT_W-1:0]  rx_level,
   input  logic              rx_overrun_pulse,
   input  logic              mode_fault_pulse,
   input  logic              tx_underrun_pulse,
   output logic              irq
);

   localparam int USED_W = (CNT_W > NUM_IRQ) ? CNT_W : NUM_IRQ;
   localparam logic [CNT_W-1:0] TX_THR_INIT = CNT_W'(TX_THR_RST);
   localparam logic [CNT_W-1:0] RX_THR_INIT = CNT_W'(RX_THR_RST);

   if (ADDR_W < 8) begin : g_chk_addr
      $error("ADDR_W must cover the 8-bit register offsets");
   end
   if (DATA_W <= USED_W) begin : g_chk_data
      $error("DATA_W must exceed both CNT_W and the status width");
   end
   if (TX_DEPTH >= (1 << CNT_W) || RX_DEPTH >= (1 << CNT_W)) begin : g_chk_depth
      $error("CNT_W too narrow for FIFO depth");
   end
   if (TX_THR_RST > TX_DEPTH || RX_THR_RST > RX_DEPTH) begin : g_chk_thr
      $error("Reset threshold exceeds FIFO depth");
   end

   wr_sel_t              wsel;
   logic [NUM_IRQ-1:0]   status_q;
   logic [NUM_IRQ-1:0]   mask_q;
   logic [CNT_W-1:0]     tx_thr_q;
   logic [CNT_W-1:0]     rx_thr_q;
   logic [NUM_IRQ-1:0]   cond;
   logic [NUM_IRQ-1:0]   rst_val;
   logic [NUM_IRQ-1:0]   clr_vec;
   logic                 lv_tx_low, lv_tx_full, lv_rx_avail, lv_rx_full;
   logic                 r0_tx_low, r0_tx_full, r0_rx_avail, r0_rx_full;
   logic                 unused_wdata_hi;

   assign unused_wdata_hi = ^wdata[DATA_W-1:USED_W];

   fic_reg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_port (
      .wr_en  (wr_en),
      .addr   (addr),
      .status (status_q),
      .mask   (mask_q),
      .tx_thr (tx_thr_q),
      .rx_thr (rx_thr_q),
      .wsel   (wsel),
      .rdata  (rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_thr_q <= TX_THR_INIT;
         rx_thr_q <= RX_THR_INIT;
      end else begin
         if (wsel.txthr_wr) tx_thr_q <= wdata[CNT_W-1:0];
         if (wsel.rxthr_wr) rx_thr_q <= wdata[CNT_W-1:0];
      end
   end

   // Live conditions against the programmed thresholds
   fic_cond_eval #(.CNT_W(CNT_W), .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) i_live (
      .tx_level (tx_level),
      .rx_level (rx_level),
      .tx_thr   (tx_thr_q),
      .rx_thr   (rx_thr_q),
      .tx_low   (lv_tx_low),
      .tx_full  (lv_tx_full),
      .rx_avail (lv_rx_avail),
      .rx_full  (lv_rx_full)
   );

   // Conditions against reset thresholds, used as status reset value
   fic_cond_eval #(.CNT_W(CNT_W), .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) i_rstv (
      .tx_level (tx_level),
      .rx_level (rx_level),
      .tx_thr   (TX_THR_INIT),
      .rx_thr   (RX_THR_INIT),
      .tx_low   (r0_tx_low),
      .tx_full  (r0_tx_full),
      .rx_avail (r0_rx_avail),
      .rx_full  (r0_rx_full)
   );

   always_comb begin
      cond             = '0;
      cond[B_RX_OVR]   = rx_overrun_pulse;
      cond[B_MODE_FLT] = mode_fault_pulse;
      cond[B_TX_LOW]   = lv_tx_low;
      cond[B_TX_FULL]  = lv_tx_full;
      cond[B_RX_AVAIL] = lv_rx_avail;
      cond[B_RX_FULL]  = lv_rx_full;
      cond[B_TX_UNDR]  = tx_underrun_pulse;

      rst_val             = '0;
      rst_val[B_TX_LOW]   = r0_tx_low;
      rst_val[B_TX_FULL]  = r0_tx_full;
      rst_val[B_RX_AVAIL] = r0_rx_avail;
      rst_val[B_RX_FULL]  = r0_rx_full;
   end

   assign clr_vec = wsel.sts_clr ? wdata[NUM_IRQ-1:0] : '0;

   fic_status_bank #(.NUM(NUM_IRQ), .LEVEL(LEVEL_BITS)) i_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .cond    (cond),
      .clr     (clr_vec),
      .rst_val (rst_val),
      .status  (status_q)
   );

   fic_mask_reg #(.NUM(NUM_IRQ)) i_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (wsel.msk_set),
      .clr_en (wsel.msk_clr),
      .bits   (wdata[NUM_IRQ-1:0]),
      .mask   (mask_q)
   );

   assign irq = |(status_q & mask_q);

endmodule

// File: rtl/fifo_irq_ctrl_chk.sv
module fifo_irq_ctrl_chk
   import fic_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  addr,
   input logic [DATA_W-1:0]  wdata,
   input logic [CNT_W-1:0]   tx_level,
   input logic               mode_fault_pulse,
   input logic               irq,
   input logic [NUM_IRQ-1:0] status_q,
   input logic [NUM_IRQ-1:0] mask_q,
   input logic [CNT_W-1:0]   tx_thr_q
);

   logic sts_wr, mset_wr, mclr_wr;
   assign sts_wr  = wr_en && (addr == ADDR_W'(OFF_STATUS));
   assign mset_wr = wr_en && (addr == ADDR_W'(OFF_MSET));
   assign mclr_wr = wr_en && (addr == ADDR_W'(OFF_MCLR));

   p_mask_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mset_wr |=> (mask_q == ($past(mask_q) | $past(wdata[NUM_IRQ-1:0]))));

   p_mask_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mclr_wr |=> (mask_q == ($past(mask_q) & ~$past(wdata[NUM_IRQ-1:0]))));

   p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mset_wr || mclr_wr) |=> $stable(mask_q));

   p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !sts_wr |=> (($past(status_q) & ~status_q) == '0));

   p_fault_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mode_fault_pulse |=> status_q[B_MODE_FLT]);

   p_tx_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((tx_level < tx_thr_q) && !(sts_wr && wdata[B_TX_LOW])) |=> status_q[B_TX_LOW]);

   p_level_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr && wdata[B_TX_LOW]) |=> !status_q[B_TX_LOW]);

   p_no_mask_no_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq);

endmodule

bind fifo_irq_ctrl fifo_irq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .wr_en            (wr_en),
   .addr             (addr),
   .wdata            (wdata),
   .tx_level         (tx_level),
   .mode_fault_pulse (mode_fault_pulse),
   .irq              (irq),
   .status_q         (status_q),
   .mask_q           (mask_q),
   .tx_thr_q         (tx_thr_q)
);

// File: tb/test_fifo_irq_ctrl.sv
`timescale 1ns/1ps
module test_fifo_irq_ctrl;

   localparam int ADDR_W = 8;
   localparam int DATA_W = 32;
   localparam int CNT_W  = 7;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] rdata;
   logic [CNT_W-1:0]  tx_level = '0;
   logic [CNT_W-1:0]  rx_level = '0;
   logic              rx_overrun_pulse = 1'b0;
   logic              mode_fault_pulse = 1'b0;
   logic              tx_underrun_pulse = 1'b0;
   logic              irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   fifo_irq_ctrl i_fifo_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .tx_level(tx_level), .rx_level(rx_level),
      .rx_overrun_pulse(rx_overrun_pulse), .mode_fault_pulse(mode_fault_pulse),
      .tx_underrun_pulse(tx_underrun_pulse), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic reg_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
      addr = a;
      #1;
      check(req, rdata, exp);
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic quiesce();
      @(negedge clk);
      tx_level = 7'd10; rx_level = 7'd0;
      step();
      reg_wr(8'h04, 32'h7F);
   endtask

   task automatic t_reset();
      reg_chk("R2 status", 8'h04, 32'h04);
      reg_chk("R2 mask", 8'h10, 32'h00);
      reg_chk("R2 tx threshold", 8'h28, 32'h01);
      reg_chk("R2 rx threshold", 8'h2C, 32'h01);
      check("R10 irq at reset", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_tx_thr();
      quiesce();
      reg_chk("R7 clear all", 8'h04, 32'h00);
      reg_wr(8'h28, 32'h08);
      reg_chk("R1 tx threshold readback", 8'h28, 32'h08);
      step();
      reg_chk("R3 count 10 below 8 false", 8'h04, 32'h00);
      tx_level = 7'd7;
      step();
      reg_chk("R3 count 7 below 8", 8'h04, 32'h04);
      reg_wr(8'h28, 32'h01);
      quiesce();
   endtask

   task automatic t_rx();
      rx_level = 7'd3;
      step();
      reg_chk("R4 not empty at threshold 1", 8'h04, 32'h10);
      quiesce();
      reg_wr(8'h2C, 32'd32);
      reg_chk("R1 rx threshold readback", 8'h2C, 32'd32);
      rx_level = 7'd31;
      step();
      reg_chk("R4 31 below 32", 8'h04, 32'h00);
      rx_level = 7'd32;
      step();
      reg_chk("R4 32 reaches 32", 8'h04, 32'h10);
      quiesce();
   endtask

   task automatic t_full();
      tx_level = 7'd63; rx_level = 7'd63;
      step();
      reg_chk("R5 both full", 8'h04, 32'h38);
      tx_level = 7'd10; rx_level = 7'd0;
      step();
      reg_chk("R11 sticky after drop", 8'h04, 32'h38);
      quiesce();
   endtask

   task automatic t_strobes();
      rx_overrun_pulse = 1'b1; mode_fault_pulse = 1'b1; tx_underrun_pulse = 1'b1;
      step();
      rx_overrun_pulse = 1'b0; mode_fault_pulse = 1'b0; tx_underrun_pulse = 1'b0;
      reg_chk("R6 strobes latched", 8'h04, 32'h43);
      step();
      reg_chk("R11 strobes held", 8'h04, 32'h43);
      reg_wr(8'h04, 32'h02);
      reg_chk("R7 clear bit 1 only", 8'h04, 32'h41);
      @(negedge clk);
      wr_en = 1'b1; addr = 8'h04; wdata = 32'h02; mode_fault_pulse = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0; mode_fault_pulse = 1'b0;
      reg_chk("R6 strobe beats clear", 8'h04, 32'h43);
      quiesce();
   endtask

   task automatic t_relevel();
      tx_level = 7'd0;
      step();
      reg_chk("R3 empty sets bit 2", 8'h04, 32'h04);
      reg_wr(8'h04, 32'h04);
      reg_chk("R8 cleared cycle", 8'h04, 32'h00);
      step();
      reg_chk("R8 set again", 8'h04, 32'h04);
   endtask

   task automatic t_mask();
      check("R10 irq with empty mask", {31'b0, irq}, 32'h0);
      reg_wr(8'h08, 32'h05);
      reg_chk("R9 set bits", 8'h10, 32'h05);
      check("R10 irq masked in", {31'b0, irq}, 32'h1);
      reg_wr(8'h0C, 32'h01);
      reg_chk("R9 clear bit 0", 8'h10, 32'h04);
      reg_wr(8'h08, 32'h00);
      reg_chk("R9 zero write no effect", 8'h10, 32'h04);
      reg_wr(8'h0C, 32'h04);
      reg_chk("R9 clear bit 2", 8'h10, 32'h00);
      check("R10 irq masked out", {31'b0, irq}, 32'h0);
      reg_wr(8'h08, 32'h02);
      check("R10 mask without status", {31'b0, irq}, 32'h0);
      reg_chk("R1 set offset reads 0", 8'h08, 32'h0);
      reg_chk("R1 clear offset reads 0", 8'h0C, 32'h0);
      reg_chk("R1 unmapped reads 0", 8'h18, 32'h0);
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      step();
      t_tx_thr();
      t_rx();
      t_full();
      t_strobes();
      t_relevel();
      t_mask();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule